// File: doc/BRIEF.md
# External Control Bus Request Generator

This block sits behind the load/store pipeline and converts one external-control request into a single bus transaction to a special-purpose device. A request is either an in-direction transfer, which reads a word from the device, or an out-direction transfer, which writes a word to it. The translated effective address is placed on the address lines as an operand for the device. The device itself is chosen by a 4-bit resource identifier. That identifier is taken from the low nibble of a resource-ID source register and carried on the burst line and the three size lines, which lose their usual transfer-attribute meaning. Every transfer is implicitly one 4-byte word.

The block screens each request before any bus activity. A misaligned operand address ends the request with an alignment exception. An address in a segment whose T bit is set ends it with a data-storage exception. If address translation is disabled the request is a programming error, but the bus cycle still runs and the block drives an address of zero. One request is handled at a time. The pipeline may present the next request only after the current one has signalled completion.

Top module: `ext_ctl_bus_gen`

## Requirements
- R1: After reset `req_ready` is 1, and `bus_valid`, `done`, `exc_align`, `exc_dsi` and `rdata` are all 0.
- R2: A request whose `req_ea[1:0]` is not `2'b00` completes with `exc_align`=1 and `exc_dsi`=0, and `bus_valid` never rises for it.
- R3: A word-aligned request with `seg_t`=1 completes with `exc_dsi`=1 and `exc_align`=0, and `bus_valid` never rises for it.
- R4: If a request is both misaligned and in a T segment, only the alignment exception is reported. At most one exception flag is ever 1, and a flag is 1 only while `done` is 1.
- R5: With `xlate_en`=1 and no exception, `bus_addr` equals the request's `req_ea` for as long as `bus_valid` is 1.
- R6: With `xlate_en`=0 and no exception, the bus cycle still runs to completion with `bus_addr` driven as 0 and no exception flag.
- R7: While `bus_valid` is 1, `bus_burst` equals bit 3 of `rid_src` (resource-ID field bit 28) and `bus_size` equals `rid_src[2:0]` (field bits 29 to 31). These values are captured when the request is accepted.
- R8: An out-direction request (`req_is_out`=1) drives `bus_write`=1 and `req_wdata` on `bus_wdata` while `bus_valid` is 1. An in-direction request drives `bus_write`=0.
- R9: An in-direction request captures `bus_rdata` at the clock edge where `bus_ack` is sampled 1 and presents it on `rdata` while `done` is 1. `rdata` holds its value through exceptions and out-direction requests.
- R10: A request is accepted only while `req_ready` is 1. `req_valid` asserted while busy is ignored and has no effect on the bus or on the next result.
- R11: `bus_addr`, `bus_burst`, `bus_size`, `bus_write` and `bus_wdata` stay stable from the rise of `bus_valid` until `bus_ack` is sampled.
- R12: `done` is a one-cycle pulse. It appears one cycle after acceptance for an exception, and one cycle after the `bus_ack` edge for a bus transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is accepted this cycle |
| req_is_out | input | 1 | 1 = out-direction (write), 0 = in-direction (read) |
| req_ea | input | 32 | Translated effective address |
| req_wdata | input | 32 | Store data for out-direction |
| rid_src | input | 32 | Resource-ID source register; low nibble used |
| seg_t | input | 1 | Segment T bit of the addressed location |
| xlate_en | input | 1 | Data address translation enabled |
| done | output | 1 | One-cycle completion pulse |
| exc_align | output | 1 | Alignment exception, valid with done |
| exc_dsi | output | 1 | Data-storage exception, valid with done |
| rdata | output | 32 | Read data from the last in-direction transfer |
| bus_valid | output | 1 | Bus transaction in progress |
| bus_addr | output | 32 | Address operand passed to the device |
| bus_write | output | 1 | Transfer direction on the bus |
| bus_burst | output | 1 | Resource-ID field bit 28 |
| bus_size | output | 3 | Resource-ID field bits 29 to 31 |
| bus_wdata | output | 32 | Write data during the data phase |
| bus_ack | input | 1 | Device acknowledge |
| bus_rdata | input | 32 | Device read data, valid with bus_ack |

## Verification
The embedded properties check, on every cycle, the handshake shape. That covers the single-cycle `done` pulse, the one-hot exception flags tied to `done`, the mutual exclusion of `req_ready` and `bus_valid`, and bus fields held steady while the block waits for an acknowledge. They also check that a non-exception completion always follows an acknowledged bus cycle. Only the bench scenarios can show the data-dependent results. These are the actual address, resource-ID bits and write data seen on the bus for given inputs, the exception priority, the zero address when translation is off, read data capture, and that a request arriving during a busy period leaves no trace.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int XFER_BYTES = 4;
  localparam int OFS_W      = $clog2(XFER_BYTES);
  localparam int RID_W      = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_ALIGN = 2'd1,
    EXC_DSI   = 2'd2
  } exc_kind_t;

  // Word alignment: low offset bits must be zero.
  function automatic logic off_word(input logic [OFS_W-1:0] lsbs);
    return |lsbs;
  endfunction

  // Alignment outranks the segment check.
  function automatic exc_kind_t pick_exc(input logic misal, input logic tseg);
    if (misal)     return EXC_ALIGN;
    else if (tseg) return EXC_DSI;
    else           return EXC_NONE;
  endfunction
endpackage

// File: rtl/ecb_classify.sv
module ecb_classify
  import ecb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ea,
  input  logic          seg_t,
  output exc_kind_t     kind
);
  logic misal;
  assign misal = off_word(ea[OFS_W-1:0]);
  assign kind  = pick_exc(misal, seg_t);

  always_comb begin
    a_r4_align_wins: assert (!(misal && kind != EXC_ALIGN));
  end
endmodule

// File: rtl/ecb_rid_map.sv
module ecb_rid_map
  import ecb_pkg::*;
(
  input  logic             active,
  input  logic [RID_W-1:0] rid,
  output logic             burst,
  output logic [2:0]       size
);
  // Field bit 28 is the MSB of the nibble and goes to the burst line.
  assign burst = active & rid[RID_W-1];
  assign size  = active ? rid[RID_W-2:0] : 3'b000;
endmodule

// File: rtl/ecb_seq.sv
module ecb_seq
  import ecb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_is_out,
  input  logic [AW-1:0]    req_ea,
  input  logic [DW-1:0]    req_wdata,
  input  logic [RID_W-1:0] rid_in,
  input  logic             xlate_en,
  input  exc_kind_t        kind_in,
  input  logic             bus_ack,
  input  logic [DW-1:0]    bus_rdata,
  output logic             req_ready,
  output logic             bus_valid,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_write,
  output logic [DW-1:0]    bus_wdata,
  output logic [RID_W-1:0] rid_q,
  output logic             done,
  output logic             exc_align,
  output logic             exc_dsi,
  output logic [DW-1:0]    rdata
);
  seq_state_t    st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic [DW-1:0] rdat_q;
  logic          out_q;
  exc_kind_t     exc_q;

  // Named internal events
  logic accept_ev, ack_ev;
  assign accept_ev = req_valid && (st_q == ST_IDLE);
  assign ack_ev    = (st_q == ST_BUS) && bus_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      out_q  <= 1'b0;
      exc_q  <= EXC_NONE;
      rid_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept_ev) begin
          addr_q <= xlate_en ? req_ea : '0;
          wdat_q <= req_wdata;
          out_q  <= req_is_out;
          rid_q  <= rid_in;
          exc_q  <= kind_in;
          st_q   <= (kind_in == EXC_NONE) ? ST_BUS : ST_FIN;
        end
        ST_BUS: if (ack_ev) begin
          if (!out_q) rdat_q <= bus_rdata;
          st_q <= ST_FIN;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign bus_valid = (st_q == ST_BUS);
  assign bus_addr  = bus_valid ? addr_q : '0;
  assign bus_write = bus_valid & out_q;
  assign bus_wdata = (bus_valid && out_q) ? wdat_q : '0;
  assign done      = (st_q == ST_FIN);
  assign exc_align = done && (exc_q == EXC_ALIGN);
  assign exc_dsi   = done && (exc_q == EXC_DSI);
  assign rdata     = rdat_q;

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_exc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_align, exc_dsi}) && ((exc_align || exc_dsi) -> done));
  a_r10_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && bus_valid));
  a_r11_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) &&
      $stable(bus_write) && $stable(bus_wdata) && $stable(rid_q)));
  a_r12_bus_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !exc_align && !exc_dsi) |-> $past(bus_valid && bus_ack));
endmodule

// File: rtl/ext_ctl_bus_gen.sv
module ext_ctl_bus_gen
  import ecb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_is_out,
  input  logic [AW-1:0] req_ea,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] rid_src,
  input  logic          seg_t,
  input  logic          xlate_en,
  output logic          done,
  output logic          exc_align,
  output logic          exc_dsi,
  output logic [DW-1:0] rdata,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          bus_burst,
  output logic [2:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  exc_kind_t        kind_w;
  logic [RID_W-1:0] rid_q_w;

  ecb_classify #(.AW(AW)) u_cls (
    .ea(req_ea), .seg_t(seg_t), .kind(kind_w)
  );

  ecb_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_out(req_is_out),
    .req_ea(req_ea), .req_wdata(req_wdata), .rid_in(rid_src[RID_W-1:0]),
    .xlate_en(xlate_en), .kind_in(kind_w), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .req_ready(req_ready), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .rid_q(rid_q_w), .done(done), .exc_align(exc_align), .exc_dsi(exc_dsi),
    .rdata(rdata)
  );

  ecb_rid_map u_rid (
    .active(bus_valid), .rid(rid_q_w), .burst(bus_burst), .size(bus_size)
  );

  a_r7_sideband_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (!bus_burst && bus_size == 3'b000));
endmodule

// File: tb/tb_ext_ctl_bus_gen.sv
module tb_ext_ctl_bus_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_is_out = 0, seg_t = 0, xlate_en = 1;
  logic [31:0] req_ea = 0, req_wdata = 0, rid_src = 0;
  logic        bus_ack = 0;
  logic [31:0] bus_rdata = 0;
  logic        req_ready, done, exc_align, exc_dsi, bus_valid, bus_write, bus_burst;
  logic [31:0] rdata, bus_addr, bus_wdata;
  logic [2:0]  bus_size;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] last_rd = 0;

  always #2 clk = ~clk;

  ext_ctl_bus_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_out(req_is_out), .req_ea(req_ea), .req_wdata(req_wdata),
    .rid_src(rid_src), .seg_t(seg_t), .xlate_en(xlate_en), .done(done),
    .exc_align(exc_align), .exc_dsi(exc_dsi), .rdata(rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_burst(bus_burst), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic        is_out;
    logic [31:0] ea;
    logic [31:0] wd;
    logic [31:0] rid;
    logic        tseg;
    logic        xen;
    logic [3:0]  dly;
    logic [31:0] rd;
    logic [1:0]  exc;   // 0 none, 1 align, 2 dsi
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h1000_0004, 32'h0,         32'h0000_0005, 1'b0, 1'b1, 4'd0, 32'hDEAD_BEEF, 2'd0},
    '{1'b1, 32'h2000_0010, 32'hA5A5_0F0F, 32'hFFFF_FFFA, 1'b0, 1'b1, 4'd3, 32'h0,         2'd0},
    '{1'b0, 32'h1000_0002, 32'h0,         32'h0000_0003, 1'b0, 1'b1, 4'd0, 32'h1111_1111, 2'd1},
    '{1'b1, 32'h4000_0020, 32'h0BAD_0BAD, 32'h0000_0007, 1'b1, 1'b1, 4'd0, 32'h0,         2'd2},
    '{1'b0, 32'h4000_0021, 32'h0,         32'h0000_0007, 1'b1, 1'b1, 4'd0, 32'h2222_2222, 2'd1},
    '{1'b0, 32'h3000_0008, 32'h0,         32'h0000_0006, 1'b0, 1'b0, 4'd2, 32'h1234_5678, 2'd0},
    '{1'b1, 32'hFFFF_FFFC, 32'h5555_AAAA, 32'h0000_0008, 1'b0, 1'b1, 4'd1, 32'h0,         2'd0},
    '{1'b0, 32'h0000_0000, 32'h0,         32'h0000_000F, 1'b0, 1'b1, 4'd5, 32'hCAFE_F00D, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Issues one request; busy_poke raises req_valid with other fields mid-transfer.
  task automatic run_req(input vec_t v, input bit busy_poke);
    int   waited = 0;
    bit   saw_bus = 0, saw_done = 0;
    int   bus_rises = 0;
    logic prev_bv = 0;
    logic [31:0] exp_addr = v.xen ? v.ea : 32'h0;
    @(negedge clk);
    req_valid = 1; req_is_out = v.is_out; req_ea = v.ea; req_wdata = v.wd;
    rid_src = v.rid; seg_t = v.tseg; xlate_en = v.xen;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R10 ready low after accept", {31'h0, req_ready}, 32'h0);
    for (int n = 0; n < 40 && !saw_done; n++) begin
      bus_ack = 0;
      if (bus_valid && !prev_bv) bus_rises++;
      prev_bv = bus_valid;
      if (bus_valid) begin
        if (!saw_bus) begin
          saw_bus = 1;
          chk(bus_addr == exp_addr, v.xen ? "R5 bus_addr" : "R6 bus_addr zero", bus_addr, exp_addr);
          chk(bus_burst == v.rid[3], "R7 burst", {31'h0, bus_burst}, {31'h0, v.rid[3]});
          chk(bus_size == v.rid[2:0], "R7 size", {29'h0, bus_size}, {29'h0, v.rid[2:0]});
          chk(bus_write == v.is_out, "R8 write", {31'h0, bus_write}, {31'h0, v.is_out});
          if (v.is_out) chk(bus_wdata == v.wd, "R8 wdata", bus_wdata, v.wd);
          if (busy_poke) begin
            req_valid = 1; req_ea = 32'h7777_7770; rid_src = 32'h9; req_is_out = ~v.is_out;
          end
        end else begin
          chk(bus_addr == exp_addr && bus_size == v.rid[2:0], "R11 stable", bus_addr, exp_addr);
        end
        if (waited == v.dly) begin
          bus_ack = 1; bus_rdata = v.rd;
        end
        waited++;
      end
      if (done) begin
        saw_done = 1;
        chk(exc_align == (v.exc == 2'd1), "R2 R4 exc_align", {31'h0, exc_align}, {31'h0, v.exc == 2'd1});
        chk(exc_dsi == (v.exc == 2'd2), "R3 R4 exc_dsi", {31'h0, exc_dsi}, {31'h0, v.exc == 2'd2});
        if (v.exc == 2'd0 && !v.is_out) last_rd = v.rd;
        chk(rdata == last_rd, "R9 rdata", rdata, last_rd);
      end
      @(negedge clk);
    end
    bus_ack = 0;
    req_valid = 0;
    chk(saw_done, "R12 done seen", {31'h0, saw_done}, 32'h1);
    chk(saw_bus == (v.exc == 2'd0), "R2 R3 R6 bus issued", {31'h0, saw_bus}, {31'h0, v.exc == 2'd0});
    chk(done == 0, "R12 done one cycle", {31'h0, done}, 32'h0);
    chk(req_ready == 1 && !bus_valid, "R10 idle after done", {31'h0, bus_valid}, 32'h0);
    chk(bus_rises <= 1, "R10 single transaction", bus_rises, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready", {31'h0, req_ready}, 32'h1);
    chk(!bus_valid && !done && !exc_align && !exc_dsi, "R1 idle outputs", {28'h0, bus_valid, done, exc_align, exc_dsi}, 32'h0);
    chk(rdata == 0, "R1 rdata", rdata, 32'h0);

    for (int i = 0; i < NV; i++) run_req(VECS[i], 1'b0);

    // R10: request asserted during busy phase is ignored
    v = '{1'b0, 32'h5000_0004, 32'h0, 32'h0000_000C, 1'b0, 1'b1, 4'd2, 32'h600D_CAFE, 2'd0};
    run_req(v, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk(!bus_valid && !done, "R10 ignored request left no trace", {30'h0, bus_valid, done}, 32'h0);
    end
    // R9: out-direction keeps rdata
    v = '{1'b1, 32'h5000_0008, 32'h1357_9BDF, 32'h0000_0001, 1'b0, 1'b1, 4'd0, 32'hFFFF_FFFF, 2'd0};
    run_req(v, 1'b0);
    chk(rdata == 32'h600D_CAFE, "R9 rdata held after out", rdata, 32'h600D_CAFE);
    finish_run();
  end
endmodule